// File: doc/BRIEF.md
# Two-Bank SDRAM Command Sequencer

This block sits between a simple host port and an SDR SDRAM device that has two internal banks, an 11-bit row address and a 9-bit column address. The host raises a request with a flat word address, a direction bit and, for writes, a data word. It holds them until the block returns a one-cycle acknowledge. For each request the block opens the addressed row, issues a single column command with the auto-precharge flag set, and waits out the precharge time before it accepts more work. Reads are captured from the device data bus after the programmed CAS latency and handed back with the acknowledge.

After reset the block precharges every bank and loads the mode register once, with a burst length of one, sequential ordering and the configured CAS latency. From then on a free-running interval timer marks a refresh as due. A due refresh is served as soon as the sequencer is idle, ahead of any waiting host request, and it is never inserted in the middle of an access. On every cycle that carries no real command, the chip select is held active and a NOP is driven. The wait counts for row-to-column delay, precharge, refresh recovery and mode-register settling are parameters given in clock cycles. The sequencer requires `T_RCD`, `T_RFC` and `T_MRD` of at least 2, `T_RP` of at least 1, and `CAS_LAT` of 1, 2 or 3.

Top module: `sdrc_cmd_ctrl`

## Requirements
- R1: While reset is high, the clock enable is low, the bus shows a NOP and the acknowledge is low. Once reset is released, the clock enable goes high.
- R2: The first commands after reset are a precharge with A10 high, then a mode load exactly `T_RP`+1 cycles later. The mode load drives A[6:4] = CAS latency and every other address bit 0, which selects burst length 1 and sequential order. No row is opened before the mode load.
- R3: Commands are coded as {cs_n, ras_n, cas_n, we_n}: mode load 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. cs_n is never high after reset, and every cycle without a command is a NOP.
- R4: The flat host address splits as column = addr[8:0], row = addr[19:9], bank = addr[20]. An activate drives the row on A[10:0] and the bank on the bank pin. The column command drives the column on A[8:0], A9 = 0 and A10 = 1 (auto-precharge), with the same bank.
- R5: The column command follows its activate by exactly `T_RCD` cycles.
- R6: Read data is sampled on the clock edge `CAS_LAT` cycles after the edge that registers the read. The acknowledge and the read word appear in the cycle `CAS_LAT`+1 after the read command.
- R7: The data-out enable is high only in the write command cycle, and in that cycle the data-out bus carries the host write word. A write is acknowledged in the cycle right after the write command.
- R8: The acknowledge is a single-cycle pulse, given exactly once per host request.
- R9: After an acknowledge, no activate or refresh is issued for at least `T_RP`+2 cycles.
- R10: Refresh commands are spaced by `REF_INTERVAL` cycles on average. Each gap stays within a short slack of that value. A refresh is issued only when no row is open.
- R11: After a refresh, the next non-NOP command comes no sooner than `T_RFC`+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Host request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | BANK_W+ROW_W+COL_W | Flat word address |
| host_wdata | input | DATA_W | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with acknowledge |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_a | output | ROW_W | Multiplexed address bus |
| sd_dq_out | output | DATA_W | Data toward the device |
| sd_dq_oe | output | 1 | Data-out enable |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
The bench counts cycles at each falling edge and stamps every command it sees. It then compares the gaps with fixed expectations: the column command `T_RCD` after its activate, the read acknowledge `CAS_LAT`+1 after the read, the write acknowledge one cycle after the write, and at least `T_RP`+2 and `T_RFC`+1 cycles of quiet after an acknowledge or a refresh. Its device model takes the word due for a read on the `CAS_LAT`-th falling edge after the command and drives noise on every other cycle, so a capture that is off by one cycle returns the wrong word. Refresh spacing is measured from one refresh to the next against `REF_INTERVAL`, with a slack that covers one whole access.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

    // Command pins packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        S_RESET,
        S_PREALL,
        S_PRE_W,
        S_LMR,
        S_LMR_W,
        S_IDLE,
        S_ACT,
        S_RCD,
        S_COL,
        S_LAT,
        S_DONE,
        S_RECOV,
        S_REF,
        S_RFC
    } ctrl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Command placed on the bus while the sequencer sits in a state
    function automatic sd_cmd_e state_cmd(input ctrl_state_e s, input logic wr);
        case (s)
            S_PREALL: return CMD_PRE;
            S_LMR:    return CMD_LMR;
            S_ACT:    return CMD_ACT;
            S_COL:    return wr ? CMD_WR : CMD_RD;
            S_REF:    return CMD_REF;
            default:  return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdrc_addr_map.sv
module sdrc_addr_map #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 11,
    parameter int COL_W  = 9,
    localparam int AW    = BANK_W + ROW_W + COL_W
) (
    input  logic [AW-1:0]     flat_addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // column in the low bits, then row, bank on top
    assign col  = flat_addr[COL_W-1:0];
    assign row  = flat_addr[COL_W +: ROW_W];
    assign bank = flat_addr[AW-1 -: BANK_W];
endmodule

// File: rtl/sdrc_refresh_timer.sv
module sdrc_refresh_timer #(
    parameter int REF_INTERVAL = 1562,
    localparam int CNT_W       = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_issued,
    output logic ref_due
);
    logic [CNT_W-1:0] tick;
    logic             wrap;

    assign wrap = (tick == CNT_W'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick    <= '0;
            ref_due <= 1'b0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap)
                ref_due <= 1'b1;
            else if (ref_issued)
                ref_due <= 1'b0;
        end
    end
endmodule

// File: rtl/sdrc_read_capture.sv
module sdrc_read_capture #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CAS_LAT-1:0] flight;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (rst) flight <= '0;
                else     flight <= rd_issue;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (rst) flight <= '0;
                else     flight <= {flight[CAS_LAT-2:0], rd_issue};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= flight[CAS_LAT-1];
            if (flight[CAS_LAT-1])
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdrc_cmd_ctrl.sv
module sdrc_cmd_ctrl
    import sdrc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int BANK_W       = 1,
    parameter int ROW_W        = 11,
    parameter int COL_W        = 9,
    parameter int AP_BIT       = 10,
    parameter int CAS_LAT      = 2,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RFC        = 7,
    parameter int T_MRD        = 2,
    parameter int REF_INTERVAL = 1562
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            host_req,
    input  logic                            host_we,
    input  logic [BANK_W+ROW_W+COL_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]               host_wdata,
    output logic                            host_ack,
    output logic [DATA_W-1:0]               host_rdata,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_a,
    output logic [DATA_W-1:0]               sd_dq_out,
    output logic                            sd_dq_oe,
    input  logic [DATA_W-1:0]               sd_dq_in
);
    localparam int AW     = BANK_W + ROW_W + COL_W;
    localparam int WMAX   = max2(max2(T_RCD, T_RP), max2(max2(T_RFC, T_MRD), CAS_LAT));
    localparam int WCNT_W = $clog2(WMAX + 1);

    typedef struct packed {
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
    } access_t;

    ctrl_state_e       state;
    logic [WCNT_W-1:0] wcnt;
    access_t           cur;
    logic              we_q;
    logic              ref_due;
    logic              ref_issued;
    logic              rd_issue;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [BANK_W-1:0] map_bank;
    logic [ROW_W-1:0]  map_row;
    logic [COL_W-1:0]  map_col;
    logic              wait_over;
    sd_cmd_e           cmd;

    sdrc_addr_map #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_map (
        .flat_addr (host_addr),
        .bank      (map_bank),
        .row       (map_row),
        .col       (map_col)
    );

    sdrc_refresh_timer #(
        .REF_INTERVAL (REF_INTERVAL)
    ) u_ref (
        .clk        (clk),
        .rst        (rst),
        .ref_issued (ref_issued),
        .ref_due    (ref_due)
    );

    sdrc_read_capture #(
        .DATA_W  (DATA_W),
        .CAS_LAT (CAS_LAT)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rd_issue (rd_issue),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign wait_over  = (wcnt == '0);
    assign we_q       = cur.we;
    assign ref_issued = (state == S_REF);
    assign rd_issue   = (state == S_COL) && !cur.we;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_RESET;
            wcnt   <= '0;
            cur    <= '0;
            sd_cke <= 1'b0;
        end else begin
            sd_cke <= 1'b1;
            case (state)
                S_RESET:  state <= S_PREALL;
                S_PREALL: begin
                    wcnt  <= WCNT_W'(T_RP - 1);
                    state <= S_PRE_W;
                end
                S_PRE_W: begin
                    if (wait_over) state <= S_LMR;
                    else           wcnt  <= wcnt - 1'b1;
                end
                S_LMR: begin
                    wcnt  <= WCNT_W'(T_MRD - 2);
                    state <= S_LMR_W;
                end
                S_LMR_W: begin
                    if (wait_over) state <= S_IDLE;
                    else           wcnt  <= wcnt - 1'b1;
                end
                S_IDLE: begin
                    if (ref_due) begin
                        state <= S_REF;
                    end else if (host_req) begin
                        cur.we    <= host_we;
                        cur.bank  <= map_bank;
                        cur.row   <= map_row;
                        cur.col   <= map_col;
                        cur.wdata <= host_wdata;
                        state     <= S_ACT;
                    end
                end
                S_ACT: begin
                    wcnt  <= WCNT_W'(T_RCD - 2);
                    state <= S_RCD;
                end
                S_RCD: begin
                    if (wait_over) state <= S_COL;
                    else           wcnt  <= wcnt - 1'b1;
                end
                S_COL: begin
                    if (cur.we) begin
                        state <= S_DONE;
                    end else begin
                        wcnt  <= WCNT_W'(CAS_LAT - 1);
                        state <= S_LAT;
                    end
                end
                S_LAT: begin
                    if (wait_over) state <= S_DONE;
                    else           wcnt  <= wcnt - 1'b1;
                end
                S_DONE: begin
                    wcnt  <= WCNT_W'(T_RP - 1);
                    state <= S_RECOV;
                end
                S_RECOV: begin
                    if (wait_over) state <= S_IDLE;
                    else           wcnt  <= wcnt - 1'b1;
                end
                S_REF: begin
                    wcnt  <= WCNT_W'(T_RFC - 2);
                    state <= S_RFC;
                end
                S_RFC: begin
                    if (wait_over) state <= S_IDLE;
                    else           wcnt  <= wcnt - 1'b1;
                end
                default: state <= S_RESET;
            endcase
        end
    end

    // Bus drive decoded from the state register
    assign cmd = state_cmd(state, cur.we);
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    always_comb begin
        sd_a  = '0;
        sd_ba = '0;
        case (state)
            S_PREALL: sd_a[AP_BIT] = 1'b1;
            S_LMR:    sd_a[6:4]    = 3'(CAS_LAT);
            S_ACT: begin
                sd_a  = cur.row;
                sd_ba = cur.bank;
            end
            S_COL: begin
                sd_a[COL_W-1:0] = cur.col;
                sd_a[AP_BIT]    = 1'b1;
                sd_ba           = cur.bank;
            end
            default: ;
        endcase
    end

    assign sd_dq_out  = cur.wdata;
    assign sd_dq_oe   = (state == S_COL) && cur.we;
    assign host_ack   = (state == S_DONE);
    assign host_rdata = rd_data;

endmodule

// File: rtl/sdrc_cmd_ctrl_checker.sv
module sdrc_cmd_ctrl_checker #(
    parameter int T_RCD  = 2,
    parameter int T_RFC  = 7,
    parameter int AP_BIT = 10,
    parameter int ABUS_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ABUS_W-1:0] addr,
    input logic              dq_oe,
    input logic              ack,
    input logic              acc_we,
    input logic              rd_valid
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [3:0]  cmd;
    logic        is_act;
    logic        is_col;
    logic        is_ref;
    logic        is_nop;
    logic [15:0] since_act;
    logic [15:0] since_ref;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == 4'b0011);
    assign is_col = (cmd == 4'b0100) || (cmd == 4'b0101);
    assign is_ref = (cmd == 4'b0001);
    assign is_nop = (cmd == 4'b0111);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= SAT;
            since_ref <= SAT;
        end else begin
            since_act <= is_act ? 16'd1 : ((since_act == SAT) ? SAT : since_act + 16'd1);
            since_ref <= is_ref ? 16'd1 : ((since_ref == SAT) ? SAT : since_ref + 16'd1);
        end
    end

    a_r3_chip_selected: assert property (@(posedge clk) disable iff (rst)
        !cs_n);

    a_r4_col_autoprecharge: assert property (@(posedge clk) disable iff (rst)
        is_col |-> addr[AP_BIT]);

    a_r5_rcd_gap: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (since_act == 16'(T_RCD)));

    a_r6_read_ack_has_data: assert property (@(posedge clk) disable iff (rst)
        (ack && !acc_we) |-> rd_valid);

    a_r6_capture_only_at_ack: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ack);

    a_r7_oe_only_on_write: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == 4'b0100));

    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r11_refresh_quiet: assert property (@(posedge clk) disable iff (rst)
        (!is_nop && !is_ref) |-> (since_ref > 16'(T_RFC)));

endmodule

bind sdrc_cmd_ctrl sdrc_cmd_ctrl_checker #(
    .T_RCD  (T_RCD),
    .T_RFC  (T_RFC),
    .AP_BIT (AP_BIT),
    .ABUS_W (ROW_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (sd_cs_n),
    .ras_n    (sd_ras_n),
    .cas_n    (sd_cas_n),
    .we_n     (sd_we_n),
    .addr     (sd_a),
    .dq_oe    (sd_dq_oe),
    .ack      (host_ack),
    .acc_we   (we_q),
    .rd_valid (rd_valid)
);

// File: tb/sdrc_cmd_ctrl_test.sv
`timescale 1ns/1ps
module sdrc_cmd_ctrl_test;
    localparam int DW      = 16;
    localparam int CL      = 3;
    localparam int T_RCD   = 2;
    localparam int T_RP    = 2;
    localparam int T_RFC   = 7;
    localparam int T_MRD   = 2;
    localparam int REF_INT = 300;
    localparam int SLACK   = 20;
    localparam int AW      = 21;

    localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                           C_NOP = 4'b0111;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [0:0]    sd_ba;
    logic [10:0]   sd_a;
    logic [DW-1:0] sd_dq_out;
    logic          sd_dq_oe;
    logic [DW-1:0] sd_dq_in = '0;

    sdrc_cmd_ctrl #(
        .DATA_W(DW), .CAS_LAT(CL), .T_RCD(T_RCD), .T_RP(T_RP),
        .T_RFC(T_RFC), .T_MRD(T_MRD), .REF_INTERVAL(REF_INT)
    ) uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dq_in(sd_dq_in)
    );

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int n_req = 0;
    int n_ack = 0;
    int n_ref = 0;
    int cs_bad = 0;
    int code_bad = 0;
    int oe_bad = 0;
    bit done = 0;

    // expectations for the request in flight
    logic          exp_we;
    logic [0:0]    exp_bank;
    logic [10:0]   exp_row;
    logic [8:0]    exp_col;
    logic [DW-1:0] exp_wdata;

    logic [DW-1:0] shadow [int unsigned];
    logic [DW-1:0] devmem [int unsigned];

    function automatic logic [DW-1:0] fill(input int unsigned key);
        return DW'((key * 32'h9E37) ^ 32'h5A5A);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // ---------------- bus monitor and device model ----------------
    int            pre_cyc = -1;
    int            act_cyc = -1;
    int            col_cyc = -1;
    int            ack_cyc = -1;
    int            ref_cyc = -1;
    bit            lmr_seen = 0;
    bit            row_open = 0;
    bit            col_was_wr = 0;
    logic [10:0]   open_row;
    int            pend_cnt = 0;
    logic [DW-1:0] pend_data;

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0]  c;
            int unsigned key;
            cyc++;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (sd_cs_n) cs_bad++;
            if (!(c inside {C_LMR, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_NOP})) code_bad++;
            if (sd_dq_oe && c != C_WR) oe_bad++;

            // device output: word due now, noise otherwise
            if (pend_cnt > 0) begin
                pend_cnt--;
                sd_dq_in <= (pend_cnt == 0) ? pend_data : DW'($urandom);
            end else begin
                sd_dq_in <= DW'($urandom);
            end

            case (c)
                C_PRE: begin
                    check(sd_a[10] == 1'b1, "R2", "precharge-all A10", sd_a[10], 1);
                    pre_cyc = cyc;
                end
                C_LMR: begin
                    check(cyc - pre_cyc == T_RP + 1, "R2", "mode load gap", cyc - pre_cyc, T_RP + 1);
                    check(sd_a == 11'(CL << 4), "R2", "mode word", sd_a, CL << 4);
                    lmr_seen = 1;
                end
                C_ACT: begin
                    check(lmr_seen, "R2", "activate after mode load", lmr_seen, 1);
                    check(sd_ba == exp_bank && sd_a == exp_row, "R4", "activate bank/row",
                          {sd_ba, sd_a}, {exp_bank, exp_row});
                    check(!row_open, "R10", "activate with row open", row_open, 0);
                    if (ack_cyc >= 0)
                        check(cyc - ack_cyc >= T_RP + 2, "R9", "activate after ack", cyc - ack_cyc, T_RP + 2);
                    if (ref_cyc >= 0)
                        check(cyc - ref_cyc >= T_RFC + 1, "R11", "activate after refresh", cyc - ref_cyc, T_RFC + 1);
                    row_open = 1;
                    open_row = sd_a;
                    act_cyc = cyc;
                end
                C_RD, C_WR: begin
                    check(cyc - act_cyc == T_RCD, "R5", "column after activate", cyc - act_cyc, T_RCD);
                    check(sd_a[10] && !sd_a[9] && sd_a[8:0] == exp_col && sd_ba == exp_bank,
                          "R4", "column address", {sd_ba, sd_a}, {exp_bank, 2'b10, exp_col});
                    key = {sd_ba, open_row, sd_a[8:0]};
                    row_open = 0;
                    col_cyc = cyc;
                    col_was_wr = (c == C_WR);
                    if (c == C_WR) begin
                        check(sd_dq_oe && sd_dq_out == exp_wdata, "R7", "write data",
                              {sd_dq_oe, sd_dq_out}, {1'b1, exp_wdata});
                        devmem[key] = sd_dq_out;
                    end else begin
                        pend_data = devmem.exists(key) ? devmem[key] : fill(key);
                        pend_cnt = CL;
                    end
                end
                C_REF: begin
                    check(!row_open, "R10", "refresh with row open", row_open, 0);
                    if (ref_cyc >= 0)
                        check(cyc - ref_cyc >= REF_INT - SLACK && cyc - ref_cyc <= REF_INT + SLACK,
                              "R10", "refresh spacing", cyc - ref_cyc, REF_INT);
                    if (ack_cyc >= 0)
                        check(cyc - ack_cyc >= T_RP + 2, "R9", "refresh after ack", cyc - ack_cyc, T_RP + 2);
                    ref_cyc = cyc;
                    n_ref++;
                end
                default: ;
            endcase

            if (host_ack) begin
                n_ack++;
                if (col_was_wr)
                    check(cyc - col_cyc == 1, "R7", "write ack timing", cyc - col_cyc, 1);
                else
                    check(cyc - col_cyc == CL + 1, "R6", "read ack timing", cyc - col_cyc, CL + 1);
                ack_cyc = cyc;
            end
        end
    end

    // ---------------- host driver ----------------
    task automatic access(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] data);
        int waited;
        @(negedge clk);
        exp_we    = we;
        exp_bank  = addr[20];
        exp_row   = addr[19:9];
        exp_col   = addr[8:0];
        exp_wdata = data;
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = addr;
        host_wdata = data;
        n_req++;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!host_ack && waited < 200);
        check(host_ack, "R8", "ack arrives", host_ack, 1);
        if (!we)
            check(host_rdata == (shadow.exists(addr) ? shadow[addr] : fill(addr)), "R6",
                  "read word", host_rdata, shadow.exists(addr) ? shadow[addr] : fill(addr));
        else
            shadow[addr] = data;
        host_req = 1'b0;
        @(negedge clk);
        check(!host_ack, "R8", "ack is one cycle", host_ack, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        summary();
    end

    initial begin
        logic [AW-1:0] a;
        // reset state
        repeat (3) @(negedge clk);
        check(!sd_cke, "R1", "cke in reset", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "nop in reset",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        check(!host_ack, "R1", "ack in reset", host_ack, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(sd_cke, "R1", "cke after reset", sd_cke, 1);

        // directed corners: address extremes and a readback of each
        access(1'b1, 21'h000000, 16'h1234);
        access(1'b0, 21'h000000, 16'h0);
        access(1'b1, 21'h1FFFFF, 16'hBEEF);
        access(1'b0, 21'h1FFFFF, 16'h0);
        access(1'b1, 21'h1001FF, 16'hA5A5);   // bank 1, row 0, last column
        access(1'b1, 21'h0FFE00, 16'h5A5A);   // bank 0, last row, column 0
        access(1'b0, 21'h1001FF, 16'h0);
        access(1'b0, 21'h0FFE00, 16'h0);
        access(1'b0, 21'h0ABCDE, 16'h0);      // never written

        // idle window: refreshes run on their own
        repeat (2 * REF_INT + 10) @(negedge clk);

        // random traffic over a small address pool so reads hit writes
        void'($urandom(32'd7));
        for (int i = 0; i < 400; i++) begin
            a = {1'($urandom), 11'($urandom % 4) << 7, 9'($urandom % 8)};
            access(1'($urandom), a, DW'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end

        repeat (20) @(negedge clk);
        done = 1;
        check(n_ack == n_req, "R8", "acks per request", n_ack, n_req);
        check(cs_bad == 0, "R3", "cycles with cs_n high", cs_bad, 0);
        check(code_bad == 0, "R3", "unknown command codes", code_bad, 0);
        check(oe_bad == 0, "R7", "oe outside write", oe_bad, 0);
        check(n_ref >= cyc / REF_INT - 1, "R10", "refresh count", n_ref, cyc / REF_INT);
        summary();
    end
endmodule